// File: doc/BRIEF.md
# Line-Code Receive Deframer

This block sits after a timing-recovery stage. It takes one hard-decided line level per strobe and turns the stream back into payload characters. Each strobed level is first compared with the level before it to undo the transition coding. The result then goes through a self-synchronising descrambler whose shift register is filled with received bits. The descrambled bits are gathered into 8-bit characters, with the first received bit in the least significant position.

Character boundaries are not known at power-up. The block hunts for them by watching every descrambled bit for the sync filler 0x7E. When it finds one it locks and counts fixed 8-bit slots from the next bit. A slot holding 0x7E is dropped without a trace. Any other slot is delivered on `byte_out` with a one-cycle `byte_vld` pulse. If too many slots in a row pass without a filler, the lock is abandoned and the hunt starts again.

Top module: `line_deframer`

## Requirements
- R1: After reset `locked` and `byte_vld` are 0, the stored previous line level is 0 and the descrambler register holds all ones, so a stream built from those same starting conditions decodes correctly from its first bit.
- R2: Only cycles with `line_vld` high carry a line bit; `line_bit` changes in cycles with `line_vld` low have no effect on decoding. Decoded bit = 1 when the strobed level equals the previous strobed level, 0 when it differs.
- R3: Each descrambled bit is the decoded bit XOR the decoded bits received 5 and 7 strobes earlier (seven-stage register fed with received decoded bits).
- R4: One wrong decoded bit at stream position k flips exactly the descrambled bits k, k+5 and k+7, which may fall into two adjacent characters; later bits are correct again.
- R5: Characters are 8 bits with the earliest bit as bit 0; `byte_vld` is high for exactly one cycle, in the cycle after the strobe that carried the slot's eighth bit.
- R6: While unlocked, the last 8 descrambled bits (earliest as bit 0) are compared with 0x7E on every strobe, at any bit offset; on a match `locked` goes high and the next bit starts a slot.
- R7: A locked slot equal to 0x7E is never delivered and restarts the missing-sync count.
- R8: While locked there is no hunting: an 0x7E pattern that straddles two slots does not move alignment, and both slots are delivered.
- R9: With `miss_limit` = N > 0, the N-th consecutive non-sync slot is still delivered, `locked` then drops, and later bits are hunted again, not delivered.
- R10: With `miss_limit` = 0 the lock is never dropped for lack of sync characters.
- R11: A run of unchanged line levels of at least 7 strobes fills the descrambler with ones, so a transmitter restarted from the all-ones state is decoded correctly after the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_bit | input | 1 | Hard line level from timing recovery |
| line_vld | input | 1 | Strobe: `line_bit` holds a new line bit this cycle |
| miss_limit | input | MISS_W (4) | Non-sync slots tolerated before the lock drops; 0 disables dropping |
| byte_out | output | 8 | Delivered payload character |
| byte_vld | output | 1 | One-cycle pulse marking `byte_out` valid |
| locked | output | 1 | Character alignment held |

## Verification
The bench builds its own transmitter (scrambler plus transition coder) and goes after the cases most likely to be got wrong. It injects a single channel error and expects bits k, k+5 and k+7 flipped. A design with the wrong taps or a synchronous descrambler would corrupt other bits or only one. It sends a 0x7E that straddles two slots while locked; a design that keeps hunting would realign and lose both bytes. It counts miss slots up to the limit, where an off-by-one design drops the lock one slot early or late. It toggles `line_bit` in every idle cycle, which a design that ignores the strobe would decode as data. It also locks at a non-byte bit offset and checks that a constant-level run resynchronises the descrambler.

// File: rtl/line_deframer_pkg.sv
// Package: shared constants for the receive deframer.
// Assumes: 8-bit characters; the sync filler value is fixed by the link.
package line_deframer_pkg;
    localparam int          CHAR_W    = 8;
    localparam logic [7:0]  SYNC_CHAR = 8'h7E;
    localparam int          SCR_LEN   = 7;
    localparam int          SCR_TAP_A = 5;
    localparam int          SCR_TAP_B = 7;
endpackage

// File: rtl/nrzi_decoder.sv
// Transition decoder: outputs 1 when the strobed level equals the previous
// strobed level, 0 when it differs. Previous level resets to 0.
// Assumes: in_vld marks the only cycles in which in_bit is meaningful.
module nrzi_decoder (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    input  logic in_vld,
    output logic dec_bit,
    output logic dec_vld
);
    logic prev_lvl;

    // Compare current level with the stored one.
    always_comb begin
        dec_bit = ~(in_bit ^ prev_lvl);
        dec_vld = in_vld;
    end

    // Remember the last strobed level.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_lvl <= 1'b0;
        else if (in_vld) prev_lvl <= in_bit;
    end

    // R2
    prev_tracks_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> prev_lvl == $past(in_bit));
endmodule

// File: rtl/self_sync_descrambler.sv
// Self-synchronising descrambler: out = in ^ reg[TAP_A] ^ reg[TAP_B], where
// the register shifts in the received (scrambled) bits. Resets to all ones.
// Assumes: TAP_A < TAP_B == LEN.
module self_sync_descrambler #(
    parameter int LEN   = 7,
    parameter int TAP_A = 5,
    parameter int TAP_B = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    input  logic in_vld,
    output logic out_bit,
    output logic out_vld
);
    logic [LEN:1] hist;

    // Remove the scrambling sequence from the current bit.
    always_comb begin
        out_bit = in_bit ^ hist[TAP_A] ^ hist[TAP_B];
        out_vld = in_vld;
    end

    // Shift received bits in; stage 1 is the most recent.
    generate
        if (LEN > 1) begin : g_shift
            always_ff @(posedge clk) begin
                if (!rst_n)      hist <= '1;
                else if (in_vld) hist <= {hist[LEN-1:1], in_bit};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n)      hist <= '1;
                else if (in_vld) hist <= in_bit;
            end
        end
    endgenerate

    // R3
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(hist));
endmodule

// File: rtl/char_aligner.sv
// Character aligner: hunts for the sync value on every bit, then assembles
// fixed slots LSB first, drops sync slots, delivers the rest, and abandons
// the lock after miss_limit consecutive non-sync slots (0 = never).
// Assumes: miss_limit is held stable while locked.
module char_aligner #(
    parameter int         W      = 8,
    parameter logic [W-1:0] SYNC = 8'h7E,
    parameter int         MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_bit,
    input  logic              in_vld,
    input  logic [MISS_W-1:0] miss_limit,
    output logic [W-1:0]      byte_out,
    output logic              byte_vld,
    output logic              locked
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0]  LAST_POS = CNT_W'(W - 1);
    localparam logic [MISS_W-1:0] MISS_MAX = '1;

    logic [W-1:0]      win;
    logic [W-1:0]      win_nxt;
    logic [CNT_W-1:0]  pos;
    logic [MISS_W-1:0] miss;
    logic              miss_hit;

    // Window after the incoming bit: earliest bit sits at bit 0.
    always_comb begin
        win_nxt  = {in_bit, win[W-1:1]};
        miss_hit = (miss_limit != '0) && ((miss + 1'b1) == miss_limit);
    end

    // Hunt, slot counting, sync stripping and lock loss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win      <= '1;
            pos      <= '0;
            miss     <= '0;
            locked   <= 1'b0;
            byte_vld <= 1'b0;
            byte_out <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (in_vld) begin
                win <= win_nxt;
                if (!locked) begin
                    if (win_nxt == SYNC) begin
                        locked <= 1'b1;
                        pos    <= '0;
                        miss   <= '0;
                    end
                end else begin
                    pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
                    if (pos == LAST_POS) begin
                        if (win_nxt == SYNC) begin
                            miss <= '0;
                        end else begin
                            byte_out <= win_nxt;
                            byte_vld <= 1'b1;
                            if (miss_hit) begin
                                locked <= 1'b0;
                                miss   <= '0;
                            end else if (miss != MISS_MAX) begin
                                miss <= miss + 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    // R5
    one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
    // R5
    pulse_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !byte_vld);
    // R6
    lock_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(in_vld));
    // R9
    miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && miss_limit != '0) |-> miss < miss_limit);
endmodule

// File: rtl/line_deframer.sv
// Receive deframer top: transition decoder -> self-synchronising
// descrambler -> character aligner with sync stripping.
// Assumes: one line bit per line_vld strobe from timing recovery.
module line_deframer #(
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_bit,
    input  logic              line_vld,
    input  logic [MISS_W-1:0] miss_limit,
    output logic [7:0]        byte_out,
    output logic              byte_vld,
    output logic              locked
);
    import line_deframer_pkg::*;

    logic dec_bit, dec_vld;
    logic dsc_bit, dsc_vld;

    nrzi_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_bit  (line_bit),
        .in_vld  (line_vld),
        .dec_bit (dec_bit),
        .dec_vld (dec_vld)
    );

    self_sync_descrambler #(
        .LEN   (SCR_LEN),
        .TAP_A (SCR_TAP_A),
        .TAP_B (SCR_TAP_B)
    ) u_dsc (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_bit  (dec_bit),
        .in_vld  (dec_vld),
        .out_bit (dsc_bit),
        .out_vld (dsc_vld)
    );

    char_aligner #(
        .W      (CHAR_W),
        .SYNC   (SYNC_CHAR),
        .MISS_W (MISS_W)
    ) u_aln (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_bit     (dsc_bit),
        .in_vld     (dsc_vld),
        .miss_limit (miss_limit),
        .byte_out   (byte_out),
        .byte_vld   (byte_vld),
        .locked     (locked)
    );
endmodule

// File: tb/line_deframer_tb_top.sv
// Directed bench: a transmitter model (scrambler + transition coder) feeds
// the deframer; each task checks its own results.
module line_deframer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_bit = 1'b0;
    logic       line_vld = 1'b0;
    logic [3:0] miss_limit = '0;
    logic [7:0] byte_out;
    logic       byte_vld;
    logic       locked;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] rx [0:63];
    int         rx_n = 0;

    logic [7:1] tx_st;
    logic       tx_lvl;
    logic       ch_inv;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_deframer dut_i (
        .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .line_vld(line_vld),
        .miss_limit(miss_limit), .byte_out(byte_out), .byte_vld(byte_vld),
        .locked(locked)
    );

    // Capture delivered bytes away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && byte_vld && rx_n < 64) begin
            rx[rx_n] = byte_out;
            rx_n = rx_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Reset both the design and the transmitter model.
    task automatic do_reset(input logic [3:0] lim);
        @(negedge clk);
        rst_n = 1'b0; line_vld = 1'b0; miss_limit = lim;
        tx_st = '1; tx_lvl = 1'b0; ch_inv = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rx_n = 0;
    endtask

    // One strobed line level, then an idle cycle with a toggled level (R2).
    task automatic put_level(input logic lvl);
        line_bit = lvl; line_vld = 1'b1;
        @(negedge clk);
        line_vld = 1'b0; line_bit = ~lvl;
        @(negedge clk);
    endtask

    // Scramble, transition-code and send one data bit; err flips the channel.
    task automatic send_bit(input logic d, input logic err);
        logic s;
        s = d ^ tx_st[5] ^ tx_st[7];
        tx_st = {tx_st[6:1], s};
        if (!s) tx_lvl = ~tx_lvl;
        if (err) ch_inv = ~ch_inv;
        put_level(tx_lvl ^ ch_inv);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i], 1'b0);
    endtask

    task automatic t_reset();
        do_reset(4'd0);
        chk("R1 locked", locked, 0);
        chk("R1 byte_vld", byte_vld, 0);
        send_byte(8'hFF); send_byte(8'hFF);
        chk("R1 no output before sync", rx_n, 0);
    endtask

    task automatic t_basic();
        logic [7:0] h;
        h = 8'h69;
        do_reset(4'd0);
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);  // odd offset, R6
        send_byte(8'hFF);
        send_byte(8'h7E);
        chk("R6 locked after sync", locked, 1);
        send_byte(8'h48);
        for (int i = 0; i < 7; i++) send_bit(h[i], 1'b0);
        send_bit(h[7], 1'b0);
        // put_level ends two negedges after the strobe: pulse already gone
        chk("R5 pulse single cycle", byte_vld, 0);
        chk("R2 R3 count", rx_n, 2);
        chk("R3 R5 byte0", rx[0], 8'h48);
        chk("R3 R5 byte1", rx[1], 8'h69);
    endtask

    task automatic t_pulse_timing();
        do_reset(4'd0);
        send_byte(8'h7E);
        for (int i = 0; i < 8; i++) begin
            line_bit = (i == 0) ? 1'b0 : 1'b0;
            if (i < 7) send_bit(1'b1, 1'b0);
        end
        // eighth bit of 0xFF, sampled in the cycle right after its strobe
        begin
            logic s;
            s = 1'b1 ^ tx_st[5] ^ tx_st[7];
            tx_st = {tx_st[6:1], s};
            if (!s) tx_lvl = ~tx_lvl;
            line_bit = tx_lvl; line_vld = 1'b1;
            @(negedge clk);
            chk("R5 byte_vld after eighth strobe", byte_vld, 1);
            chk("R5 value", byte_out, 8'hFF);
            line_vld = 1'b0;
            @(negedge clk);
            chk("R5 byte_vld one cycle", byte_vld, 0);
        end
    endtask

    task automatic t_sync_strip();
        do_reset(4'd0);
        send_byte(8'h7E); send_byte(8'h61); send_byte(8'h7E);
        send_byte(8'h7E); send_byte(8'h62); send_byte(8'h7E);
        chk("R7 count", rx_n, 2);
        chk("R7 first", rx[0], 8'h61);
        chk("R7 second", rx[1], 8'h62);
    endtask

    task automatic t_straddle();
        do_reset(4'd0);
        send_byte(8'h7E); send_byte(8'hFC); send_byte(8'h02); send_byte(8'h33);
        chk("R8 count", rx_n, 3);
        chk("R8 first", rx[0], 8'hFC);
        chk("R8 second", rx[1], 8'h02);
        chk("R8 third", rx[2], 8'h33);
    endtask

    task automatic t_error();
        logic [7:0] a;
        a = 8'h41;
        do_reset(4'd0);
        send_byte(8'h7E);
        for (int i = 0; i < 8; i++) send_bit(a[i], i == 2);
        send_byte(8'h42); send_byte(8'h43);
        chk("R4 count", rx_n, 3);
        chk("R4 first char bits 2,7", rx[0], 8'hC5);
        chk("R4 second char bit 1", rx[1], 8'h40);
        chk("R4 recovered", rx[2], 8'h43);
    endtask

    task automatic t_drop_and_run();
        do_reset(4'd3);
        send_byte(8'h7E);
        send_byte(8'h31); send_byte(8'h32); send_byte(8'h33);
        chk("R9 locked dropped", locked, 0);
        send_byte(8'h55); send_byte(8'hFF);
        chk("R9 count", rx_n, 3);
        chk("R9 third delivered", rx[2], 8'h33);
        // R11: constant line level, then a transmitter restarted at all ones
        for (int i = 0; i < 64; i++) put_level(tx_lvl);
        tx_st = '1;
        chk("R11 unlocked after run", locked, 0);
        rx_n = 0;
        send_byte(8'h7E); send_byte(8'h4F); send_byte(8'h4B);
        chk("R11 count", rx_n, 2);
        chk("R11 first", rx[0], 8'h4F);
        chk("R11 second", rx[1], 8'h4B);
    endtask

    task automatic t_nodrop();
        do_reset(4'd0);
        send_byte(8'h7E);
        for (int i = 0; i < 20; i++) send_byte(8'h20 + 8'(i));
        chk("R10 still locked", locked, 1);
        chk("R10 count", rx_n, 20);
        chk("R10 last", rx[19], 8'h33);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_pulse_timing();
        t_sync_strip();
        t_straddle();
        t_error();
        t_drop_and_run();
        t_nodrop();
        finish_run();
    end
endmodule